// File: doc/BRIEF.md
# Snooping cache line state controller

This block keeps the four-state coherence tag (Invalid, Shared, Exclusive, Modified) for every line of a small cache. It has no tag compare of its own: each request names a line slot by index. The block sees a slot in state Invalid as a miss. For each local read, write or eviction request, it picks the shared-bus transaction the request needs, or none when the access can complete locally. It then waits for that transaction's snoop result and applies the state change the result calls for.

Requests from other agents arrive as snoops. The block answers each snoop with a hit indication and a modified-hit indication. When the snooped line is Modified, it also raises an implicit-writeback request, so that the data array supplies the line as part of the other agent's transaction. For its own transactions, a deferred snoop result with no modified hit holds the state change back. That change is applied later, when the snoop phase of the deferred reply arrives. Only one local transaction is outstanding at any time. Snoop state changes never look at the deferral signal.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid (encoding I=00, S=01, E=10, M=11), `busy` and `txn_valid` are low, and a snoop to any line reports no hit.
- R2: A local read of an Invalid line with `req_rfo` set issues read-and-invalidate (code 7). When its snoop result is applied, the line becomes Modified.
- R3: A full-length read (`req_len` equal to the line size) of an Invalid line without `req_rfo` issues line read (code 1). The result makes the line Shared if `res_hit` or `res_hitm` is set, and Exclusive otherwise.
- R4: A shorter read of an Invalid line issues part read (code 2). A shorter write to an Invalid line issues part write (code 5). A full-length write to an Invalid line issues line write (code 4). None of these changes the line state.
- R5: A locked request of at most LOCK_MAX bytes issues locked read (code 3) or locked write (code 6) and changes no state. A locked request that is longer issues nothing and leaves `busy` low.
- R6: A write to a Shared line issues zero-length invalidate (code 8), and the result makes the line Modified. A write to an Exclusive line issues nothing and makes it Modified. A write to a Modified line issues nothing.
- R7: An eviction of a Modified line issues line write (code 4), and the result makes the line Invalid. An eviction of any other line issues nothing.
- R8: A snoop read that hits a Shared or Exclusive line reports hit without modified hit and leaves the line Shared. A snoop invalidate that hits makes the line Invalid.
- R9: A snoop that hits a Modified line reports hit, modified hit and implicit-writeback request, one cycle after the snoop. A snoop read leaves the line Shared, and a snoop invalidate leaves it Invalid.
- R10: A result with `res_defer` set and `res_hitm` clear leaves the line state unchanged and keeps `busy` high. The pending change is then applied, using `res_hit`/`res_hitm`, in the cycle `dly_valid` is sampled.
- R11: Snoop state changes take place whatever the level of `res_defer`. A result with both `res_defer` and `res_hitm` set is applied at once.
- R12: If a zero-length invalidate finds its line Invalid when the result arrives (another agent invalidated it first), and `res_hitm` is set, the line becomes Modified and `full_fill` pulses for one cycle. Without `res_hitm`, the line stays Invalid and `full_fill` stays low.
- R13: While `busy` is high, local requests are ignored and issue no transaction. Each issued transaction shows as a one-cycle `txn_valid` pulse on the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Local request present |
| req_write | input | 1 | Local request is a write |
| req_evict | input | 1 | Local request writes back the line |
| req_lock | input | 1 | Local request is locked |
| req_rfo | input | 1 | Read with intent to modify |
| req_idx | input | IW | Line slot of the local request |
| req_len | input | LENW | Byte length of the local request |
| busy | output | 1 | A local transaction is outstanding |
| txn_valid | output | 1 | Transaction issue pulse |
| txn_type | output | 4 | Transaction code issued |
| res_valid | input | 1 | Snoop result phase of the local transaction |
| res_defer | input | 1 | Deferral sampled in that phase |
| res_hit | input | 1 | Other agent holds the line clean |
| res_hitm | input | 1 | Other agent supplies modified data |
| dly_valid | input | 1 | Snoop phase of the deferred reply |
| full_fill | output | 1 | Accept a full line from the writeback data |
| snp_valid | input | 1 | Snoop from another agent |
| snp_inv | input | 1 | Snoop invalidates (else read) |
| snp_idx | input | IW | Line slot of the snoop |
| snp_hit | output | 1 | Snoop hit a valid line |
| snp_hitm | output | 1 | Snoop hit a Modified line |
| iwb_req | output | 1 | Implicit-writeback data request |

## Verification
Each line slot is driven through its own path of states, and the issued transaction codes and the later snoop responses reveal those states. An E-versus-S question is answered by a write that is either silent or issues an invalidate, and a clean-versus-modified question by a snoop. Read misses are tried with and without intent to modify and with a clean-hit result or none. This tells the two read codes apart and the Exclusive fill from the Shared fill. Full and partial lengths, and locked requests just under and above the lock limit, separate the length decoding. Results with deferral are tried alone, together with a modified hit, and while a snoop arrives. The invalidate race is tried with and without writeback data, and a request sent while busy shows that it is dropped.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'b00,
        LS_S = 2'b01,
        LS_E = 2'b10,
        LS_M = 2'b11
    } lstate_t;

    typedef enum logic [3:0] {
        TX_NONE    = 4'd0,
        TX_RD_LINE = 4'd1,
        TX_RD_PART = 4'd2,
        TX_RD_LOCK = 4'd3,
        TX_WR_LINE = 4'd4,
        TX_WR_PART = 4'd5,
        TX_WR_LOCK = 4'd6,
        TX_RD_INV  = 4'd7,
        TX_INV0    = 4'd8
    } txn_t;

    // State after a snoop from another agent; deferral plays no part.
    function automatic lstate_t snoop_next(lstate_t cur, logic inv);
        if (cur == LS_I) return LS_I;
        return inv ? LS_I : LS_S;
    endfunction

    // State after the snoop result of an own transaction is applied.
    function automatic lstate_t reply_next(txn_t kind, lstate_t cur,
                                           logic hit, logic hitm);
        case (kind)
            TX_RD_LINE: return (hit || hitm) ? LS_S : LS_E;
            TX_RD_INV:  return LS_M;
            TX_WR_LINE: return LS_I;
            TX_INV0:    begin
                if (cur == LS_I) return hitm ? LS_M : LS_I;
                return LS_M;
            end
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/cl_state_array.sv
module cl_state_array
    import mesi_pkg::*;
#(
    parameter int NLINES = 8,
    localparam int IW = $clog2(NLINES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lw_en,
    input  logic [IW-1:0] lw_idx,
    input  lstate_t       lw_st,
    input  logic          sw_en,
    input  logic [IW-1:0] sw_idx,
    input  lstate_t       sw_st,
    input  logic [IW-1:0] ra_idx,
    output lstate_t       ra_st,
    input  logic [IW-1:0] rb_idx,
    output lstate_t       rb_st,
    input  logic [IW-1:0] rc_idx,
    output lstate_t       rc_st
);

    lstate_t st_q [NLINES];

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst)
                    st_q[g] <= LS_I;
                else if (sw_en && sw_idx == IW'(g))
                    st_q[g] <= sw_st;     // snoop wins over local update
                else if (lw_en && lw_idx == IW'(g))
                    st_q[g] <= lw_st;
            end
        end
    endgenerate

    function automatic lstate_t rd(logic [IW-1:0] i);
        if (int'(i) >= NLINES) return LS_I;
        return st_q[i];
    endfunction

    assign ra_st = rd(ra_idx);
    assign rb_st = rd(rb_idx);
    assign rc_st = rd(rc_idx);

endmodule

// File: rtl/cl_req_decode.sv
module cl_req_decode
    import mesi_pkg::*;
#(
    parameter int LINE_BYTES = 32,
    parameter int LOCK_MAX   = 8,
    localparam int LENW = $clog2(LINE_BYTES) + 1
) (
    input  logic            write,
    input  logic            evict,
    input  logic            lock,
    input  logic            rfo,
    input  logic [LENW-1:0] len,
    input  lstate_t         cur,
    output txn_t            kind,
    output logic            silent_up
);

    localparam logic [LENW-1:0] FULL_LEN = LENW'(LINE_BYTES);
    localparam logic [LENW-1:0] LOCK_LIM = LENW'(LOCK_MAX);

    logic full;
    assign full = (len >= FULL_LEN);

    always_comb begin
        kind      = TX_NONE;
        silent_up = 1'b0;
        if (lock) begin
            if (len <= LOCK_LIM) kind = write ? TX_WR_LOCK : TX_RD_LOCK;
        end else if (evict) begin
            if (cur == LS_M) kind = TX_WR_LINE;
        end else if (write) begin
            case (cur)
                LS_E:    silent_up = 1'b1;
                LS_S:    kind = TX_INV0;
                LS_I:    kind = full ? TX_WR_LINE : TX_WR_PART;
                default: kind = TX_NONE;
            endcase
        end else if (cur == LS_I) begin
            if (rfo)       kind = TX_RD_INV;
            else if (full) kind = TX_RD_LINE;
            else           kind = TX_RD_PART;
        end
    end

    // R5: locked traffic never exceeds the lock byte limit
    always_comb begin
        p_lock_len_r5: assert (!((kind == TX_RD_LOCK) || (kind == TX_WR_LOCK)) || (len <= LOCK_LIM));
    end

endmodule

// File: rtl/cl_snoop_unit.sv
module cl_snoop_unit
    import mesi_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    snp_valid,
    input  logic    snp_inv,
    input  lstate_t cur,
    output logic    sw_en,
    output lstate_t sw_st,
    output logic    snp_hit,
    output logic    snp_hitm,
    output logic    iwb_req
);

    assign sw_en = snp_valid && (cur != LS_I);
    assign sw_st = snoop_next(cur, snp_inv);

    always_ff @(posedge clk) begin
        if (rst) begin
            snp_hit  <= 1'b0;
            snp_hitm <= 1'b0;
            iwb_req  <= 1'b0;
        end else begin
            snp_hit  <= snp_valid && (cur != LS_I);
            snp_hitm <= snp_valid && (cur == LS_M);
            iwb_req  <= snp_valid && (cur == LS_M);
        end
    end

    // R9: a modified hit is always also a hit
    p_hitm_is_hit_r9: assert property (@(posedge clk) disable iff (rst)
        snp_hitm |-> snp_hit);

    // R9: writeback requested exactly on snoop of a Modified line
    p_iwb_on_modified_r9: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && cur == LS_M) |=> iwb_req);

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int NLINES     = 8,
    parameter int LINE_BYTES = 32,
    parameter int LOCK_MAX   = 8,
    localparam int IW   = $clog2(NLINES),
    localparam int LENW = $clog2(LINE_BYTES) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic            req_evict,
    input  logic            req_lock,
    input  logic            req_rfo,
    input  logic [IW-1:0]   req_idx,
    input  logic [LENW-1:0] req_len,
    output logic            busy,
    output logic            txn_valid,
    output logic [3:0]      txn_type,
    input  logic            res_valid,
    input  logic            res_defer,
    input  logic            res_hit,
    input  logic            res_hitm,
    input  logic            dly_valid,
    output logic            full_fill,
    input  logic            snp_valid,
    input  logic            snp_inv,
    input  logic [IW-1:0]   snp_idx,
    output logic            snp_hit,
    output logic            snp_hitm,
    output logic            iwb_req
);

    typedef struct packed {
        txn_t          kind;
        logic [IW-1:0] idx;
        logic          deferred;
    } pend_t;

    pend_t   pend_q;
    logic    busy_q;
    logic    txv_q;
    txn_t    txt_q;
    logic    fill_q;

    lstate_t req_st, snp_st, pend_st, lw_st;
    lstate_t sw_st;
    logic    sw_en, lw_en;
    txn_t    dec_kind;
    logic    silent_up;

    logic req_go, defer_hold, apply;

    cl_state_array #(.NLINES(NLINES)) u_arr (
        .clk    (clk),
        .rst    (rst),
        .lw_en  (lw_en),
        .lw_idx (apply ? pend_q.idx : req_idx),
        .lw_st  (lw_st),
        .sw_en  (sw_en),
        .sw_idx (snp_idx),
        .sw_st  (sw_st),
        .ra_idx (req_idx),
        .ra_st  (req_st),
        .rb_idx (snp_idx),
        .rb_st  (snp_st),
        .rc_idx (pend_q.idx),
        .rc_st  (pend_st)
    );

    cl_req_decode #(.LINE_BYTES(LINE_BYTES), .LOCK_MAX(LOCK_MAX)) u_dec (
        .write     (req_write),
        .evict     (req_evict),
        .lock      (req_lock),
        .rfo       (req_rfo),
        .len       (req_len),
        .cur       (req_st),
        .kind      (dec_kind),
        .silent_up (silent_up)
    );

    cl_snoop_unit u_snp (
        .clk       (clk),
        .rst       (rst),
        .snp_valid (snp_valid),
        .snp_inv   (snp_inv),
        .cur       (snp_st),
        .sw_en     (sw_en),
        .sw_st     (sw_st),
        .snp_hit   (snp_hit),
        .snp_hitm  (snp_hitm),
        .iwb_req   (iwb_req)
    );

    assign req_go     = req_valid && !busy_q;
    assign defer_hold = busy_q && res_valid && !pend_q.deferred && res_defer && !res_hitm;
    assign apply      = busy_q && ((res_valid && !pend_q.deferred && !(res_defer && !res_hitm))
                                   || (dly_valid && pend_q.deferred));

    assign lw_en = apply || (req_go && silent_up);
    assign lw_st = apply ? reply_next(pend_q.kind, pend_st, res_hit, res_hitm) : LS_M;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '{kind: TX_NONE, idx: '0, deferred: 1'b0};
            busy_q <= 1'b0;
            txv_q  <= 1'b0;
            txt_q  <= TX_NONE;
            fill_q <= 1'b0;
        end else begin
            txv_q  <= 1'b0;
            fill_q <= 1'b0;
            if (req_go && dec_kind != TX_NONE) begin
                busy_q      <= 1'b1;
                pend_q.kind <= dec_kind;
                pend_q.idx  <= req_idx;
                pend_q.deferred <= 1'b0;
                txv_q       <= 1'b1;
                txt_q       <= dec_kind;
            end else if (defer_hold) begin
                pend_q.deferred <= 1'b1;
            end else if (apply) begin
                busy_q          <= 1'b0;
                pend_q.deferred <= 1'b0;
                fill_q <= (pend_q.kind == TX_INV0) && (pend_st == LS_I) && res_hitm;
            end
        end
    end

    assign busy      = busy_q;
    assign txn_valid = txv_q;
    assign txn_type  = txt_q;
    assign full_fill = fill_q;

    // R1: leaving reset nothing is outstanding or issued
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !txn_valid));

    // R13: a request during busy never produces a transaction
    p_single_outstanding_r13: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> !txn_valid);

    // R13: issue is a single-cycle pulse
    p_txn_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        txn_valid |=> !txn_valid);

    // R10: deferred result without modified hit keeps the transaction open
    p_defer_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && res_valid && res_defer && !res_hitm && !dly_valid) |=> busy);

    // R12: full-line accept follows only a zero-length invalidate
    p_fill_only_inv0_r12: assert property (@(posedge clk) disable iff (rst)
        full_fill |-> ($past(pend_q.kind) == TX_INV0));

endmodule

// File: tb/mesi_line_ctrl_test.sv
module mesi_line_ctrl_test;

    localparam int NLINES = 8;
    localparam int LB     = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 0, req_write = 0, req_evict = 0, req_lock = 0, req_rfo = 0;
    logic [2:0] req_idx = 0;
    logic [5:0] req_len = 0;
    logic       busy, txn_valid, full_fill, snp_hit, snp_hitm, iwb_req;
    logic [3:0] txn_type;
    logic       res_valid = 0, res_defer = 0, res_hit = 0, res_hitm = 0, dly_valid = 0;
    logic       snp_valid = 0, snp_inv = 0;
    logic [2:0] snp_idx = 0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    int    exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    mesi_line_ctrl #(.NLINES(NLINES), .LINE_BYTES(LB), .LOCK_MAX(8)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_evict(req_evict),
        .req_lock(req_lock), .req_rfo(req_rfo), .req_idx(req_idx), .req_len(req_len),
        .busy(busy), .txn_valid(txn_valid), .txn_type(txn_type),
        .res_valid(res_valid), .res_defer(res_defer), .res_hit(res_hit),
        .res_hitm(res_hitm), .dly_valid(dly_valid), .full_fill(full_fill),
        .snp_valid(snp_valid), .snp_inv(snp_inv), .snp_idx(snp_idx),
        .snp_hit(snp_hit), .snp_hitm(snp_hitm), .iwb_req(iwb_req)
    );

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: every issued transaction is matched against the scoreboard
    always @(negedge clk) begin
        if (!rst && txn_valid && !done) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL unexpected txn: actual %0d expected none", txn_type);
            end else begin
                chk(tag_q.pop_front(), int'(txn_type), exp_q.pop_front());
            end
        end
    end

    // Driver: one local request; exp = 0 means no transaction expected
    task automatic lreq(bit w, bit ev, bit lk, bit rfo, int idx, int len, int exp, string tag);
        @(negedge clk);
        if (exp != 0) begin exp_q.push_back(exp); tag_q.push_back(tag); end
        req_valid = 1; req_write = w; req_evict = ev; req_lock = lk; req_rfo = rfo;
        req_idx = 3'(idx); req_len = 6'(len);
        @(negedge clk);
        req_valid = 0; req_write = 0; req_evict = 0; req_lock = 0; req_rfo = 0;
    endtask

    task automatic result(bit d, bit h, bit hm, output bit ff, output bit bz);
        @(negedge clk);
        res_valid = 1; res_defer = d; res_hit = h; res_hitm = hm;
        @(negedge clk);
        res_valid = 0; res_defer = 0; res_hit = 0; res_hitm = 0;
        ff = full_fill; bz = busy;
    endtask

    task automatic dreply(bit h, bit hm, output bit bz);
        @(negedge clk);
        dly_valid = 1; res_hit = h; res_hitm = hm;
        @(negedge clk);
        dly_valid = 0; res_hit = 0; res_hitm = 0;
        bz = busy;
    endtask

    task automatic snoop(bit inv, int idx, bit eh, bit ehm, string tag);
        @(negedge clk);
        snp_valid = 1; snp_inv = inv; snp_idx = 3'(idx);
        @(negedge clk);
        snp_valid = 0; snp_inv = 0;
        chk({tag, " hit"},  snp_hit,  eh);
        chk({tag, " hitm"}, snp_hitm, ehm);
        chk({tag, " iwb"},  iwb_req,  ehm);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit ff, bz;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 txn_valid", txn_valid, 0);
        snoop(0, 0, 0, 0, "R1 snoop after reset");

        // R3 no clean hit -> E; R6 silent E->M; R9 snoop read of M
        lreq(0, 0, 0, 0, 1, LB, 1, "R3 line read");
        result(0, 0, 0, ff, bz);
        chk("R3 busy cleared", bz, 0);
        lreq(1, 0, 0, 0, 1, 4, 0, "R6 E write");
        chk("R6 silent write no busy", busy, 0);
        snoop(0, 1, 1, 1, "R9 read snoop of M");
        lreq(1, 0, 0, 0, 1, 4, 8, "R6 S write invalidate");
        result(0, 0, 0, ff, bz);
        snoop(1, 1, 1, 1, "R9 inv snoop of M");
        snoop(0, 1, 0, 0, "R9 line now I");

        // R2 read with intent to modify
        lreq(0, 0, 0, 1, 2, LB, 7, "R2 read-invalidate");
        result(0, 0, 0, ff, bz);
        snoop(0, 2, 1, 1, "R2 line is M");
        snoop(0, 2, 1, 0, "R8 read snoop leaves S");

        // R3 clean hit -> S; R10 deferred result
        lreq(0, 0, 0, 0, 3, LB, 1, "R3 line read");
        result(0, 1, 0, ff, bz);
        lreq(1, 0, 0, 0, 3, LB, 8, "R3 shared fill gives invalidate");
        result(1, 0, 0, ff, bz);
        chk("R10 busy held", bz, 1);
        snoop(0, 3, 1, 0, "R10 state unchanged while deferred");
        dreply(0, 0, bz);
        chk("R10 busy after reply", bz, 0);
        snoop(1, 3, 1, 1, "R10 applied at deferred reply");
        snoop(0, 3, 0, 0, "R8 inv snoop leaves I");

        // R4 partial and full writes/reads on a miss
        lreq(0, 0, 0, 0, 4, 8, 2, "R4 part read");
        result(0, 0, 0, ff, bz);
        lreq(1, 0, 0, 0, 4, 8, 5, "R4 part write");
        result(0, 0, 0, ff, bz);
        lreq(1, 0, 0, 0, 4, LB, 4, "R4 line write");
        result(0, 0, 0, ff, bz);
        snoop(0, 4, 0, 0, "R4 state stays I");

        // R5 locked accesses
        lreq(0, 0, 1, 0, 5, 8, 3, "R5 locked read");
        result(0, 0, 0, ff, bz);
        lreq(1, 0, 1, 0, 5, 4, 6, "R5 locked write");
        result(0, 0, 0, ff, bz);
        lreq(0, 0, 1, 0, 5, 16, 0, "R5 oversize lock");
        chk("R5 oversize no busy", busy, 0);
        snoop(0, 5, 0, 0, "R5 lock leaves I");

        // R7 eviction
        lreq(0, 1, 0, 0, 2, LB, 0, "R7 evict S");
        chk("R7 evict S no busy", busy, 0);
        lreq(0, 0, 0, 1, 6, LB, 7, "R7 setup read-invalidate");
        result(0, 0, 0, ff, bz);
        lreq(0, 1, 0, 0, 6, LB, 4, "R7 evict M");
        result(0, 0, 0, ff, bz);
        snoop(0, 6, 0, 0, "R7 evicted line I");

        // R11 snoop ignores deferral; defer with hitm applies at once
        lreq(0, 0, 0, 0, 7, LB, 1, "R11 line read");
        result(0, 0, 0, ff, bz);
        @(negedge clk); res_defer = 1;
        snoop(0, 7, 1, 0, "R11 snoop under defer");
        res_defer = 0;
        lreq(1, 0, 0, 0, 7, 4, 8, "R11 snoop moved E to S");
        result(1, 0, 1, ff, bz);
        chk("R11 defer+hitm busy", bz, 0);
        snoop(1, 7, 1, 1, "R11 applied to M");

        // R12 invalidate race
        lreq(0, 0, 0, 0, 0, LB, 1, "R12 setup read");
        result(0, 1, 0, ff, bz);
        lreq(1, 0, 0, 0, 0, 4, 8, "R12 invalidate");
        snoop(1, 0, 1, 0, "R12 other agent invalidates");
        result(0, 0, 1, ff, bz);
        chk("R12 full_fill with hitm", ff, 1);
        snoop(0, 0, 1, 1, "R12 line M after fill");
        lreq(1, 0, 0, 0, 0, 4, 8, "R12 second invalidate");
        snoop(1, 0, 1, 0, "R12 second race");
        result(0, 0, 0, ff, bz);
        chk("R12 no full_fill without hitm", ff, 0);
        snoop(0, 0, 0, 0, "R12 stays I");

        // R13 request while busy is dropped
        lreq(0, 0, 0, 0, 5, LB, 1, "R13 first read");
        lreq(0, 0, 0, 0, 4, LB, 0, "R13 dropped read");
        chk("R13 still busy", busy, 1);
        result(0, 0, 0, ff, bz);
        chk("R13 busy cleared", bz, 0);
        snoop(0, 4, 0, 0, "R13 dropped request left line I");

        repeat (3) @(negedge clk);
        chk("R13 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule